// File: doc/BRIEF.md
# Flash Controller Control Register

This block is the control register of an embedded flash controller, along with the logic that controls power for the flash control circuit. The CPU writes one byte that holds three things: a 4-bit write-protect key, a one-shot abort request, and two power-control bits, one manual and one automatic. The block uses these bits, the area the CPU is currently fetching code from and the chip's low-power mode indications to produce four outputs:

- a write-enable qualifier for the programming sequencer;
- a one-cycle abort pulse that stops a write and clears the write data counter;
- a power-on request for the flash control circuit;
- a ready flag that rises a fixed number of cycles after power comes on.

The key, the abort request and the manual power bit are protected against code that runs out of flash. They change only while the fetch-area code reports RAM or boot ROM. The automatic bit can be written from any area. Software reads the byte back combinationally. The power-up delay is the parameter `PWR_UP_CYCLES`.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset the register reads 8'hC3: key 4'b1100 in bits 7:4, bits 3 and 2 zero, automatic bit (bit 1) one and manual bit (bit 0) one. `abortPulse`, `pwrReady` and `wrEnable` are 0.
- R2: `fetchArea` is encoded as follows: 2'b00 is flash, 2'b01 is RAM, 2'b10 is boot ROM, and 2'b11 is treated as flash. A write while `fetchArea` is flash or 2'b11 leaves the key, the manual bit and the abort request unchanged, but it still updates the automatic bit from `regWrData[1]`.
- R3: A read always returns bits 3 and 2 as 0, whatever was written to them.
- R4: A write from RAM or boot ROM with `regWrData[3]`=1 drives `abortPulse` high for exactly the one clock cycle that follows the write edge. The same write from flash gives no pulse.
- R5: `pwrOn` = manual & !`stopMode` & !((`idleMode` | `sleepMode`) & !automatic). It follows the mode inputs combinationally.
- R6: While the manual bit is 0, `pwrOn` is 0 for every value of the automatic bit and every mode input, including when STOP is entered and left.
- R7: Once `pwrOn` goes high, `pwrReady` reads 0 until `PWR_UP_CYCLES` rising edges have seen `pwrOn` high, and then reads 1. `pwrReady` drops in the same cycle that `pwrOn` drops, and the count starts again the next time power comes on.
- R8: `wrEnable` is 1 only when the key is 4'b0011 and `pwrReady` is 1. The value 4'b1100 and every reserved key value keep it at 0.
- R9: A permitted write stores all 16 key values as written, and a read returns them in bits 7:4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | CPU write strobe for the register |
| regWrData | input | 8 | CPU write data |
| regRdData | output | 8 | Register read value |
| fetchArea | input | 2 | Area of the current instruction fetch (00 flash, 01 RAM, 10 boot ROM, 11 treated as flash) |
| stopMode | input | 1 | STOP mode active |
| idleMode | input | 1 | IDLE mode active |
| sleepMode | input | 1 | SLEEP mode active |
| wrEnable | output | 1 | Flash write permitted |
| abortPulse | output | 1 | One-cycle write abort and write-counter clear |
| pwrOn | output | 1 | Power request for the flash control circuit |
| pwrReady | output | 1 | Flash control circuit powered up |

## Verification
The hardest case to reach is the power-up window. `pwrReady` must stay low for exactly the programmed number of edges, and it must start counting again whenever power is interrupted, whether the manual bit clears or IDLE is entered with the automatic bit clear. The stimulus first holds power off for at least one clock edge. It then restores power at a falling edge and checks `pwrReady` at every falling edge of the window, so that an off-by-one in the counter shows up. The protection against writes from flash is swept over all 256 data bytes for both untrusted area codes. This shows that only the automatic bit moves and that no abort pulse leaks out.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  localparam int KEY_MSB   = 7;
  localparam int KEY_LSB   = 4;
  localparam int KEY_W     = KEY_MSB - KEY_LSB + 1;
  localparam int ABORT_BIT = 3;
  localparam int AUTO_BIT  = 1;
  localparam int MAN_BIT   = 0;

  localparam logic [KEY_W-1:0] KEY_UNLOCK = 4'b0011;
  localparam logic [KEY_W-1:0] KEY_LOCK   = 4'b1100;

  typedef enum logic [1:0] {
    AREA_FLASH = 2'b00,
    AREA_RAM   = 2'b01,
    AREA_BOOT  = 2'b10,
    AREA_RSVD  = 2'b11
  } fetchArea_e;

  typedef struct packed {
    logic keyLoad;
    logic manLoad;
    logic autoLoad;
    logic abortSet;
  } regStrobe_t;

endpackage

// File: rtl/flash_ctl_ctrl.sv
module flash_ctl_ctrl
  import flash_ctl_pkg::*;
#(
  parameter int PWR_UP_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       abortReq,
  input  logic [1:0] fetchArea,
  input  logic       stopMode,
  input  logic       idleMode,
  input  logic       sleepMode,
  input  logic       manBit,
  input  logic       autoBit,
  output regStrobe_t strb,
  output logic       pwrOn,
  output logic       pwrReady
);

  localparam int CNT_W = (PWR_UP_CYCLES < 2) ? 1 : $clog2(PWR_UP_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWR_UP_CYCLES - 1);

  fetchArea_e area;
  logic       trusted;
  logic       lowPwr;
  logic [CNT_W-1:0] cntQ;
  logic       readyQ;

  assign area    = fetchArea_e'(fetchArea);
  assign trusted = (area == AREA_RAM) || (area == AREA_BOOT);

  // Write strobes: protected fields need a trusted fetch area
  always_comb begin
    strb          = '0;
    strb.keyLoad  = regWrEn && trusted;
    strb.manLoad  = regWrEn && trusted;
    strb.abortSet = regWrEn && trusted && abortReq;
    strb.autoLoad = regWrEn;
  end

  // Effective power decision
  assign lowPwr = idleMode || sleepMode;
  assign pwrOn  = manBit && !stopMode && !(lowPwr && !autoBit);

  // Power-up delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      readyQ <= 1'b0;
    end else if (!pwrOn) begin
      cntQ   <= '0;
      readyQ <= 1'b0;
    end else if (!readyQ) begin
      if (cntQ == CNT_LAST) readyQ <= 1'b1;
      else                  cntQ   <= cntQ + 1'b1;
    end
  end

  assign pwrReady = readyQ && pwrOn;

  AST_MAN_GATES_POWER: assert property (@(posedge clk) disable iff (!rstN)
    !manBit |-> !pwrOn); // R6
  AST_STOP_CUTS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |-> !pwrOn); // R5
  AST_READY_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOn |-> !pwrReady); // R7
  AST_READY_AFTER_POWER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyQ) |-> $past(pwrOn)); // R7

endmodule

// File: rtl/flash_ctl_dp.sv
module flash_ctl_dp
  import flash_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [KEY_W-1:0] wrKey,
  input  logic             wrAuto,
  input  logic             wrMan,
  input  logic             pwrReady,
  output logic             manBit,
  output logic             autoBit,
  output logic [7:0]       rdData,
  output logic             abortPulse,
  output logic             wrEnable
);

  logic [KEY_W-1:0] keyQ;
  logic             manQ;
  logic             autoQ;
  logic             abortQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ   <= KEY_LOCK;
      manQ   <= 1'b1;
      autoQ  <= 1'b1;
      abortQ <= 1'b0;
    end else begin
      if (strb.keyLoad)  keyQ  <= wrKey;
      if (strb.manLoad)  manQ  <= wrMan;
      if (strb.autoLoad) autoQ <= wrAuto;
      abortQ <= strb.abortSet;
    end
  end

  always_comb begin
    rdData                  = '0;
    rdData[KEY_MSB:KEY_LSB] = keyQ;
    rdData[AUTO_BIT]        = autoQ;
    rdData[MAN_BIT]         = manQ;
  end

  assign manBit     = manQ;
  assign autoBit    = autoQ;
  assign abortPulse = abortQ;
  assign wrEnable   = (keyQ == KEY_UNLOCK) && pwrReady;

  AST_WE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    wrEnable |-> pwrReady); // R8

endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
  import flash_ctl_pkg::*;
#(
  parameter int PWR_UP_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic [1:0] fetchArea,
  input  logic       stopMode,
  input  logic       idleMode,
  input  logic       sleepMode,
  output logic       wrEnable,
  output logic       abortPulse,
  output logic       pwrOn,
  output logic       pwrReady
);

  regStrobe_t strb;
  logic       manBit;
  logic       autoBit;

  flash_ctl_ctrl #(.PWR_UP_CYCLES(PWR_UP_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .abortReq  (regWrData[ABORT_BIT]),
    .fetchArea (fetchArea),
    .stopMode  (stopMode),
    .idleMode  (idleMode),
    .sleepMode (sleepMode),
    .manBit    (manBit),
    .autoBit   (autoBit),
    .strb      (strb),
    .pwrOn     (pwrOn),
    .pwrReady  (pwrReady)
  );

  flash_ctl_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrKey      (regWrData[KEY_MSB:KEY_LSB]),
    .wrAuto     (regWrData[AUTO_BIT]),
    .wrMan      (regWrData[MAN_BIT]),
    .pwrReady   (pwrReady),
    .manBit     (manBit),
    .autoBit    (autoBit),
    .rdData     (regRdData),
    .abortPulse (abortPulse),
    .wrEnable   (wrEnable)
  );

  AST_ABORT_FROM_TRUSTED: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> $past(regWrEn && regWrData[ABORT_BIT] &&
                         (fetchArea == 2'b01 || fetchArea == 2'b10))); // R4
  AST_FLASH_FETCH_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (fetchArea == 2'b00 || fetchArea == 2'b11))
      |=> $stable(regRdData[KEY_MSB:KEY_LSB])); // R2
  AST_RESERVED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[3:2] == 2'b00); // R3
  AST_WE_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rstN)
    wrEnable |-> (regRdData[KEY_MSB:KEY_LSB] == 4'b0011)); // R8

endmodule

// File: tb/sim_flash_ctl_reg.sv
module sim_flash_ctl_reg;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic [1:0] fetchArea;
  logic       stopMode, idleMode, sleepMode;
  logic       wrEnable, abortPulse, pwrOn, pwrReady;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_ctl_reg #(.PWR_UP_CYCLES(N)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .fetchArea(fetchArea), .stopMode(stopMode),
    .idleMode(idleMode), .sleepMode(sleepMode), .wrEnable(wrEnable),
    .abortPulse(abortPulse), .pwrOn(pwrOn), .pwrReady(pwrReady)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a write at a falling edge; return at the falling edge after it lands
  task automatic wrReg(input logic [7:0] d, input logic [1:0] area);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d; fetchArea = area;
    @(negedge clk);
    regWrEn = 1'b0; fetchArea = 2'b00;
  endtask

  // Power was just restored before the edge that precedes this falling edge
  task automatic readyWindow(input string req);
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      chk(req, {7'd0, pwrReady}, 8'd0);
    end
    @(negedge clk);
    chk(req, {7'd0, pwrReady}, 8'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0; fetchArea = 2'b00;
    stopMode = 1'b0; idleMode = 1'b0; sleepMode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 read", regRdData, 8'hC3);
    chk("R1 flags", {5'd0, abortPulse, pwrReady, wrEnable}, 8'd0);
    rstN = 1'b1;
    // R7: first power-up after reset
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      chk("R7 reset window", {7'd0, pwrReady}, 8'd0);
    end
    @(negedge clk);
    chk("R7 reset ready", {7'd0, pwrReady}, 8'd1);

    // R9 / R8: every key from trusted areas
    for (int k = 0; k < 16; k++) begin
      wrReg({k[3:0], 4'b0011}, k[0] ? 2'b01 : 2'b10);
      chk("R9 key readback", regRdData, {k[3:0], 4'b0011});
      chk("R8 wrEnable", {7'd0, wrEnable}, {7'd0, k[3:0] == 4'b0011});
    end

    // R2: protection sweep from flash and reserved area
    wrReg(8'h33, 2'b01);
    for (int a = 0; a < 2; a++) begin
      for (int d = 0; d < 256; d++) begin
        wrReg(d[7:0], a == 0 ? 2'b00 : 2'b11);
        chk("R2 protected", regRdData, {4'b0011, 2'b00, d[1], 1'b1});
        chk("R4 no pulse from flash", {7'd0, abortPulse}, 8'd0);
      end
    end
    wrReg(8'h03, 2'b00);

    // R4 / R3: abort pulse and reserved bits
    for (int a = 1; a < 3; a++) begin
      wrReg(8'h3F, a[1:0]);
      chk("R4 pulse", {7'd0, abortPulse}, 8'd1);
      chk("R3 read bits 3:2", regRdData, 8'h33);
      @(negedge clk);
      chk("R4 pulse width", {7'd0, abortPulse}, 8'd0);
    end

    // R5 / R6: power decision over all bits and modes
    for (int m = 0; m < 2; m++) begin
      for (int au = 0; au < 2; au++) begin
        wrReg({4'b0011, 2'b00, au[0], m[0]}, 2'b01);
        for (int md = 0; md < 8; md++) begin
          @(negedge clk);
          stopMode = md[0]; idleMode = md[1]; sleepMode = md[2];
          #1;
          chk(m == 0 ? "R6 manual off" : "R5 power",
              {7'd0, pwrOn},
              {7'd0, m[0] && !md[0] && !((md[1] || md[2]) && !au[0])});
          if (!pwrOn) chk("R7 ready drops", {7'd0, pwrReady}, 8'd0);
          @(negedge clk);
          stopMode = 1'b0; idleMode = 1'b0; sleepMode = 1'b0;
        end
      end
    end

    // R7 / R8: manual bit 0 -> 1 restarts the window
    wrReg(8'h32, 2'b01);
    chk("R8 no enable unpowered", {6'd0, wrEnable, pwrOn}, 8'd0);
    wrReg(8'h33, 2'b10);
    readyWindow("R7 manual restart");
    chk("R8 enable when ready", {7'd0, wrEnable}, 8'd1);

    // R7: idle with automatic bit clear, then wake
    wrReg(8'h31, 2'b00);
    @(negedge clk);
    idleMode = 1'b1;
    #1;
    chk("R7 immediate drop", {6'd0, pwrReady, wrEnable}, 8'd0);
    @(negedge clk);
    idleMode = 1'b0;
    readyWindow("R7 idle restart");
    chk("R8 enable after wake", {7'd0, wrEnable}, 8'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule